// File: doc/BRIEF.md
# Two-way set-associative instruction cache

A read-only cache for a 32-bit core's instruction fetches. It sits between a CPU fetch port and an external memory port that returns one 32-bit longword per handshake. Each lookup takes two addresses from the CPU. The effective address picks the set and the word within the line. The translated physical address supplies the tag that is compared. Each of the two ways holds 256 lines of eight longwords. Each set has one shared replacement bit that names the way to evict next.

A hit returns the instruction in the same cycle the request is seen. A miss starts a line refill at the requested longword and continues with wraparound order. The first word goes straight to the CPU. The line only becomes valid after all eight longwords have been stored. A fetch is uncached when the enable input is low or the cacheable flag is low. An uncached fetch is one longword read that leaves the cache state alone.

The block has two resets. Power-on reset clears every valid bit and every replacement bit. Manual reset clears every valid bit but keeps the replacement bits. Neither reset touches the data storage.

Top module: `icache_2way`

## Requirements
- R1: The set is chosen by fetch_ea[12:5]. On a hit, fetch_ea[4:2] chooses which longword of the line appears on fetch_data.
- R2: The tag is fetch_pa[28:10]. A fetch hits only when a way of the chosen set holds that tag with its valid bit set. Any other case is a miss, and at most one way hits.
- R3: A cached hit raises fetch_ready in the cycle in which fetch_req is first seen, with no memory request.
- R4: A miss reads eight longwords at {fetch_pa[31:5], w, 2'b00}. w starts at fetch_ea[4:2] and counts up modulo 8. mem_addr holds steady while mem_req waits for mem_ack.
- R5: On a miss, fetch_ready and the requested word appear in the cycle of the first memory beat, which is one cycle after the request. fetch_ready does not repeat for the rest of the refill.
- R6: When the eighth beat completes, the tag and valid bit of the filled way are written. After that, all eight words of the line hit and return the data that was stored.
- R7: On a miss, the way named by the set's replacement bit is filled. After power-on reset that way is way 0. A hit or a completed refill makes the bit name the other way.
- R8: Power-on reset clears all valid bits and replacement bits and leaves fetch_ready and mem_req low. A one-cycle mrst pulse clears all valid bits and leaves the replacement bits unchanged.
- R9: When cache_en or fetch_cacheable is 0, the fetch is a single memory read at {fetch_pa[31:2], 2'b00}. That read is returned in its beat cycle and does not change tags, valid bits or replacement bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, active high |
| cache_en | input | 1 | Cache enable |
| fetch_req | input | 1 | Fetch request, held until fetch_ready |
| fetch_cacheable | input | 1 | Fetch targets a cacheable area |
| fetch_ea | input | 32 | Effective fetch address |
| fetch_pa | input | 32 | Translated physical fetch address |
| fetch_ready | output | 1 | Instruction valid on fetch_data this cycle |
| fetch_data | output | 32 | Instruction longword |
| mem_req | output | 1 | External read request |
| mem_addr | output | 32 | External byte address, longword aligned |
| mem_ack | input | 1 | External beat accepted, mem_data valid |
| mem_data | input | 32 | External read data |

## Verification
Each result has a fixed due cycle. A hit is due in the request cycle itself. A refill or uncached read delivers its word in the cycle after the request, and the remaining seven refill beats follow one per cycle. The bench drives inputs on the falling edge and samples one time unit later. It counts falling edges from request to fetch_ready, compares that count to the expected latency, and counts memory beats until mem_req drops. Memory contents carry a generation number that the bench changes between fetches, so a stale value proves a hit and a fresh value proves a memory read.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FILL   = 2'd1,
      ST_BYPASS = 2'd2
   } ic_state_e;
endpackage

// File: rtl/icache_tag_way.sv
module icache_tag_way #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_valid,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] cmp_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             hit
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid_q <= '0;
      else if (clr_valid) valid_q <= '0;
      else if (wr_en)     valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_idx] <= wr_tag;
   end

   assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);

   // R6: a committed line is found by the next lookup of the same set and tag
   p_fill_then_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_valid) |=>
         (!(rd_idx == $past(wr_idx) && cmp_tag == $past(wr_tag)) || hit));
endmodule

// File: rtl/icache_data_way.sv
module icache_data_way #(
   parameter int IDX_W  = 8,
   parameter int WORD_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << (IDX_W + WORD_W);

   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store_q[{wr_idx, wr_word}] <= wr_data;
   end

   assign rd_data = store_q[{rd_idx, rd_word}];
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             victim
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0] lru_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lru_q <= '0;
      else if (upd_en && !freeze) lru_q[upd_idx] <= ~upd_way;
   end

   assign victim = lru_q[rd_idx];

   // R7: after an access the set names the other way as victim
   p_points_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !freeze) |=> (lru_q[$past(upd_idx)] != $past(upd_way)));

   // R8: manual reset leaves the replacement bits untouched
   p_kept_by_mrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> (lru_q == $past(lru_q)));
endmodule

// File: rtl/icache_2way.sv
module icache_2way
   import icache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SETS       = 256,
   parameter int LINE_WORDS = 8,
   parameter int NUM_WAYS   = 2,
   parameter int TAG_LSB    = 10,
   parameter int TAG_MSB    = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrst,
   input  logic              cache_en,
   input  logic              fetch_req,
   input  logic              fetch_cacheable,
   input  logic [ADDR_W-1:0] fetch_ea,
   input  logic [ADDR_W-1:0] fetch_pa,
   output logic              fetch_ready,
   output logic [DATA_W-1:0] fetch_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_data
);
   localparam int BYTE_W  = $clog2(DATA_W / 8);
   localparam int WORD_W  = $clog2(LINE_WORDS);
   localparam int IDX_W   = $clog2(SETS);
   localparam int IDX_LSB = BYTE_W + WORD_W;
   localparam int BASE_W  = ADDR_W - IDX_LSB;
   localparam int TAG_W   = TAG_MSB - TAG_LSB + 1;
   localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

   if (NUM_WAYS != 2) begin : g_bad_ways
      $error("icache_2way: NUM_WAYS must be 2 (one replacement bit per set)");
   end
   if ((1 << WORD_W) != LINE_WORDS || (1 << IDX_W) != SETS) begin : g_bad_pow2
      $error("icache_2way: LINE_WORDS and SETS must be powers of two");
   end
   if (TAG_MSB >= ADDR_W || TAG_LSB > IDX_LSB + IDX_W) begin : g_bad_tag
      $error("icache_2way: tag field must lie in the address and reach the index");
   end

   ic_state_e state_q;

   logic [IDX_W-1:0]  look_idx;
   logic [WORD_W-1:0] look_word;
   logic [TAG_W-1:0]  look_tag;
   logic              use_cache, any_hit, hit_way, victim;
   logic              hit_take, miss_take, beat, last;
   logic [NUM_WAYS-1:0] hit_vec;
   logic [DATA_W-1:0]   way_rd [NUM_WAYS];

   logic [IDX_W-1:0]  fill_idx_q;
   logic [TAG_W-1:0]  fill_tag_q;
   logic [WORD_W-1:0] fill_start_q, beat_q, cur_word;
   logic [BASE_W-1:0] fill_base_q;
   logic              fill_way_q;

   assign look_idx  = fetch_ea[IDX_LSB +: IDX_W];
   assign look_word = fetch_ea[BYTE_W +: WORD_W];
   assign look_tag  = fetch_pa[TAG_MSB:TAG_LSB];
   assign use_cache = cache_en && fetch_cacheable;

   assign any_hit   = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign hit_take  = (state_q == ST_IDLE) && fetch_req && !mrst && use_cache && any_hit;
   assign miss_take = (state_q == ST_IDLE) && fetch_req && !mrst && !(use_cache && any_hit);
   assign beat      = mem_req && mem_ack;
   assign last      = (beat_q == LAST_BEAT);
   assign cur_word  = fill_start_q + beat_q;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic fill_here;
      assign fill_here = (state_q == ST_FILL) && beat && (fill_way_q == 1'(w));

      icache_tag_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_valid (mrst),
         .rd_idx    (look_idx),
         .cmp_tag   (look_tag),
         .wr_en     (fill_here && last && !mrst),
         .wr_idx    (fill_idx_q),
         .wr_tag    (fill_tag_q),
         .hit       (hit_vec[w])
      );

      icache_data_way #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_data (
         .clk     (clk),
         .wr_en   (fill_here),
         .wr_idx  (fill_idx_q),
         .wr_word (cur_word),
         .wr_data (mem_data),
         .rd_idx  (look_idx),
         .rd_word (look_word),
         .rd_data (way_rd[w])
      );
   end

   icache_lru #(.IDX_W(IDX_W)) u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .freeze  (mrst),
      .upd_en  (hit_take || ((state_q == ST_FILL) && beat && last)),
      .upd_idx ((state_q == ST_IDLE) ? look_idx : fill_idx_q),
      .upd_way ((state_q == ST_IDLE) ? hit_way : fill_way_q),
      .rd_idx  (look_idx),
      .victim  (victim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else if (mrst) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               beat_q <= '0;
               if (miss_take) state_q <= use_cache ? ST_FILL : ST_BYPASS;
            end
            ST_FILL: if (beat) begin
               beat_q <= beat_q + 1'b1;
               if (last) state_q <= ST_IDLE;
            end
            ST_BYPASS: if (beat) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (miss_take) begin
         fill_idx_q   <= look_idx;
         fill_tag_q   <= look_tag;
         fill_start_q <= look_word;
         fill_base_q  <= fetch_pa[ADDR_W-1:IDX_LSB];
         fill_way_q   <= victim;
      end
   end

   assign mem_req     = (state_q != ST_IDLE);
   assign mem_addr    = {fill_base_q, cur_word, {BYTE_W{1'b0}}};
   assign fetch_ready = hit_take
                      || ((state_q == ST_FILL) && beat && (beat_q == '0))
                      || ((state_q == ST_BYPASS) && beat);
   assign fetch_data  = (state_q == ST_IDLE) ? (hit_way ? way_rd[1] : way_rd[0]) : mem_data;

   // R2: a tag is never resident in both ways of a set
   p_one_way_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R4: a waiting memory request keeps its address
   p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n || mrst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R5: the requested word is delivered once per refill
   p_ready_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_FILL) && fetch_ready) |=> !fetch_ready);
endmodule

// File: tb/tb_icache_2way.sv
module tb_icache_2way;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] ea;
      logic [31:0] pa;
      logic        cach;
      logic        en;
      logic [7:0]  gen;
      logic [3:0]  beats;
      logic [7:0]  dgen;
      logic [1:0]  lat;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_0104, 32'h0000_0104, 1'b1, 1'b1, 8'd0, 4'd8, 8'd0, 2'd1},
      '{32'h0000_0108, 32'h0000_0108, 1'b1, 1'b1, 8'd1, 4'd0, 8'd0, 2'd0},
      '{32'h0000_2108, 32'h0000_2108, 1'b1, 1'b1, 8'd1, 4'd8, 8'd1, 2'd1},
      '{32'h0000_0104, 32'h0000_0104, 1'b1, 1'b1, 8'd2, 4'd0, 8'd0, 2'd0},
      '{32'h0000_2104, 32'h0000_2104, 1'b1, 1'b1, 8'd2, 4'd0, 8'd1, 2'd0},
      '{32'h0000_4100, 32'h0000_4100, 1'b1, 1'b1, 8'd2, 4'd8, 8'd2, 2'd1},
      '{32'h0000_2100, 32'h0000_2100, 1'b1, 1'b1, 8'd2, 4'd0, 8'd1, 2'd0},
      '{32'h0000_0104, 32'h0000_0104, 1'b1, 1'b1, 8'd2, 4'd8, 8'd2, 2'd1},
      '{32'h0000_0600, 32'h0000_0600, 1'b0, 1'b1, 8'd2, 4'd1, 8'd2, 2'd1},
      '{32'h0000_0600, 32'h0000_0600, 1'b1, 1'b1, 8'd3, 4'd8, 8'd3, 2'd1},
      '{32'h0000_0604, 32'h0000_0604, 1'b1, 1'b0, 8'd4, 4'd1, 8'd4, 2'd1},
      '{32'h0000_0604, 32'h0000_0604, 1'b1, 1'b1, 8'd4, 4'd0, 8'd3, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mrst = 1'b0;
   logic        cache_en = 1'b0;
   logic        fetch_req = 1'b0;
   logic        fetch_cacheable = 1'b0;
   logic [31:0] fetch_ea = '0;
   logic [31:0] fetch_pa = '0;
   logic        fetch_ready;
   logic [31:0] fetch_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_data;
   logic [7:0]  gen = '0;

   int          n_checks = 0;
   int          n_fails = 0;
   logic [31:0] seen [8];

   function automatic logic [31:0] memword(input logic [31:0] a, input logic [7:0] g);
      return {g, a[23:0]};
   endfunction

   assign mem_ack  = mem_req;
   assign mem_data = memword(mem_addr, gen);

   always #(CLK_PERIOD / 2) clk = ~clk;

   icache_2way dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .mrst            (mrst),
      .cache_en        (cache_en),
      .fetch_req       (fetch_req),
      .fetch_cacheable (fetch_cacheable),
      .fetch_ea        (fetch_ea),
      .fetch_pa        (fetch_pa),
      .fetch_ready     (fetch_ready),
      .fetch_data      (fetch_data),
      .mem_req         (mem_req),
      .mem_addr        (mem_addr),
      .mem_ack         (mem_ack),
      .mem_data        (mem_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [31:0] ea, input logic [31:0] pa, input logic cach,
                           input logic en, output logic [31:0] data, output int beats,
                           output int lat);
      int  cyc;
      logic got;
      @(negedge clk);
      fetch_ea = ea; fetch_pa = pa; fetch_cacheable = cach; cache_en = en; fetch_req = 1'b1;
      cyc = 0; beats = 0; got = 1'b0; data = '0; lat = -1;
      while (!got && cyc < 40) begin
         #1;
         if (mem_req && mem_ack) begin seen[beats % 8] = mem_addr; beats++; end
         if (fetch_ready) begin
            got = 1'b1; data = fetch_data; lat = cyc;
         end else begin
            @(negedge clk); cyc++;
         end
      end
      if (!got) chk("watchdog fetch_ready", 32'd0, 32'd1);
      got = 1'b0; cyc = 0;
      while (!got && cyc < 40) begin
         @(negedge clk);
         fetch_req = 1'b0;
         #1;
         if (mem_req && mem_ack) begin seen[beats % 8] = mem_addr; beats++; end
         else got = 1'b1;
         cyc++;
      end
      if (!got) chk("watchdog mem_req", 32'd0, 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int          b, l;
      string       tg;

      repeat (3) @(negedge clk);
      #1;
      chk("R8 reset fetch_ready", 32'(fetch_ready), 32'd0);
      chk("R8 reset mem_req", 32'(mem_req), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R2 R3 R5 R7 R9
      for (int i = 0; i < NVEC; i++) begin
         gen = VECS[i].gen;
         do_fetch(VECS[i].ea, VECS[i].pa, VECS[i].cach, VECS[i].en, d, b, l);
         tg = (VECS[i].beats == 4'd0) ? "R3 hit" : (VECS[i].beats == 4'd1) ? "R9 bypass" : "R7 miss";
         chk($sformatf("%s vec %0d data", tg, i), d,
             memword({VECS[i].pa[31:2], 2'b00}, VECS[i].dgen));
         chk($sformatf("R2 vec %0d beats", i), 32'(b), 32'(VECS[i].beats));
         chk($sformatf("R5 vec %0d latency", i), 32'(l), 32'(VECS[i].lat));
      end

      // R4: wraparound from word 5
      gen = 8'd5;
      do_fetch(32'h0000_8114, 32'h0000_8114, 1'b1, 1'b1, d, b, l);
      chk("R4 refill beats", 32'(b), 32'd8);
      for (int k = 0; k < 8; k++)
         chk($sformatf("R4 beat %0d addr", k), seen[k],
             {27'h0000_8100 >> 5, 3'((5 + k) % 8), 2'b00});
      chk("R5 critical word", d, memword(32'h0000_8114, 8'd5));

      // R6: every word of the completed line hits with stored data
      gen = 8'd6;
      for (int k = 0; k < 8; k++) begin
         do_fetch(32'h0000_8100 + 32'(4 * k), 32'h0000_8100 + 32'(4 * k), 1'b1, 1'b1, d, b, l);
         chk($sformatf("R6 word %0d data", k), d, memword(32'h0000_8100 + 32'(4 * k), 8'd5));
         chk($sformatf("R1 word %0d no traffic", k), 32'(b), 32'd0);
      end

      // R1/R2: index from EA, tag from PA
      gen = 8'd7;
      do_fetch(32'h0000_0F14, 32'h0000_8F14, 1'b1, 1'b1, d, b, l);
      chk("R2 pa tag miss", 32'(b), 32'd8);
      gen = 8'd8;
      do_fetch(32'h0000_0F18, 32'h0000_8F18, 1'b1, 1'b1, d, b, l);
      chk("R1 ea index hit", 32'(b), 32'd0);
      chk("R1 ea index data", d, memword(32'h0000_8F18, 8'd7));
      do_fetch(32'h0000_0F18, 32'h0000_0F18, 1'b1, 1'b1, d, b, l);
      chk("R2 other pa tag misses", 32'(b), 32'd8);

      // R8: manual reset clears valid bits, both ways still usable after
      @(negedge clk); mrst = 1'b1;
      @(negedge clk); mrst = 1'b0;
      gen = 8'd9;
      do_fetch(32'h0000_8118, 32'h0000_8118, 1'b1, 1'b1, d, b, l);
      chk("R8 mrst forces miss", 32'(b), 32'd8);
      chk("R8 mrst refill data", d, memword(32'h0000_8118, 8'd9));
      do_fetch(32'h0000_A118, 32'h0000_A118, 1'b1, 1'b1, d, b, l);
      chk("R8 second way miss", 32'(b), 32'd8);
      gen = 8'd10;
      do_fetch(32'h0000_8118, 32'h0000_8118, 1'b1, 1'b1, d, b, l);
      chk("R7 first way kept", d, memword(32'h0000_8118, 8'd9));
      do_fetch(32'h0000_A118, 32'h0000_A118, 1'b1, 1'b1, d, b, l);
      chk("R7 second way kept", d, memword(32'h0000_A118, 8'd9));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule